// File: doc/BRIEF.md
# FPGA Configuration Sequencing Controller

This block walks an FPGA fabric through its configuration sequence under software control. Software reaches it through a small 32-bit register interface: a status word and a control word. Configuration words arrive on a separate write-only data port. The controller drives the active-low configuration-reset request and the active-low chip-enable toward the fabric. A mode state machine reports the fabric's phase: power-up, reset, configuration, initialization, user mode, or unknown. The fabric's handshake comes back as three plain inputs: configuration done, an active-low status, and initialization done.

The mode-select pins are sampled every cycle and shown in the status word. When software applies the configuration-reset pull with a valid mode-select code, the controller loads the data width and the clock-to-data ratio fields of the control word from that code. Configuration words pass to the fabric only while data transfer is enabled. A short final word keeps only its low bytes. Any word written while transfer is off is dropped and raises a sticky error flag. Once configuration completes, the controller issues a fixed number of completion clocks. It then waits for initialization to finish before it reports user mode.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: Register word address 0 is status. Bits [2:0] hold the mode: 0 power-up, 1 reset, 2 configuration, 3 initialization, 4 user, 5 unknown. Bits [7:3] hold the mode-select pins as sampled one cycle earlier. Bit 8 is the sticky drop-error flag. Any other address reads zero.
- R2: Register word address 1 is control and reads back only its writable bits: bit 0 enable, bit 1 active-low chip enable, bit 2 configuration-reset pull, bits [7:6] ratio code (0 x1, 1 x2, 2 x4, 3 x8), bit 8 transfer enable, bit 9 width (1 means 32-bit). The outputs `cfg_ratio` and `cfg_width32` follow these fields. `cfg_nce` is low only when enable is 1 and bit 1 is 0.
- R3: While enable and pull are both 1, `cfg_nconfig` is low. With a valid code, the mode becomes reset one cycle after the control write takes effect. Clearing pull with enable still 1 then moves the mode to configuration.
- R4: Codes 0-2, 4-6, 8-10 and 12-14 are valid. Bit 3 of the code selects 32-bit width. For 16-bit codes, bits [1:0] = 0, 1, 2 give ratio x1, x2, x4. For 32-bit codes they give x1, x4, x8. A control write that sets enable and pull with a valid sampled code stores the decoded width and ratio in place of the written ones.
- R5: A control write that sets enable and pull with an invalid code keeps the written width and ratio. The mode goes to unknown (5) and stays there after pull is cleared.
- R6: A data-port write is forwarded on `cfg_data` with `cfg_data_vld` high for exactly the next cycle, but only when enable and transfer enable are both 1.
- R7: `data_nbytes` 0 forwards all four bytes. Values 1, 2 and 3 forward that many low bytes and force the higher bytes to zero.
- R8: A data-port write that is not forwarded sets status bit 8. The bit stays set until software writes address 0 with bit 8 at 1.
- R9: In configuration mode, with configuration done and status both high, the mode goes to initialization. `cfg_dclk` is then high for exactly COMPL_CLKS cycles (default 4). After those cycles, the mode goes to user only once initialization done is high.
- R10: If the fabric status input goes low in configuration mode, the mode returns to reset. It stays there until a new pull-set then pull-clear sequence is made.
- R11: While enable is 0, the mode is frozen, `cfg_nconfig` and `cfg_nce` are high, `cfg_dclk` is low, and no data word is forwarded.
- R12: After reset, the mode is power-up, the control word is zero, both active-low outputs are high, and `cfg_dclk` and `cfg_data_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| data_wr | input | 1 | Configuration data write strobe |
| data_nbytes | input | 2 | Valid bytes of the word (0 means all four) |
| data_wdata | input | 32 | Configuration data word |
| msel_pins | input | 5 | Mode-select pins |
| fab_conf_done | input | 1 | Fabric reports configuration done |
| fab_nstatus | input | 1 | Fabric status, low on error |
| fab_init_done | input | 1 | Fabric reports initialization finished |
| cfg_nconfig | output | 1 | Configuration-reset request, active low |
| cfg_nce | output | 1 | Chip enable, active low |
| cfg_dclk | output | 1 | Completion clock enable pulse |
| cfg_width32 | output | 1 | Data width selection, 1 = 32-bit |
| cfg_ratio | output | 2 | Clock-to-data ratio code |
| cfg_data | output | 32 | Forwarded configuration word |
| cfg_data_vld | output | 1 | Forwarded word valid |

## Verification
The bench sweeps all sixteen 4-bit mode-select codes and one code with the top bit set. A decoder with a wrong 32-bit ratio mapping would leave x2 where x4 belongs. One that accepts codes ending in 3 would report reset instead of unknown. It counts completion clock pulses and holds initialization done low, so an off-by-one counter or a premature jump to user mode shows up. It drops the fabric status mid-configuration and then releases it. A design that re-arms on its own would creep back to configuration without a new reset pull. It also drives writes while enable is low: a design that does not freeze would follow the fabric status or forward data.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    MODE_PWRUP   = 3'd0,
    MODE_RESET   = 3'd1,
    MODE_CONFIG  = 3'd2,
    MODE_INIT    = 3'd3,
    MODE_USER    = 3'd4,
    MODE_UNKNOWN = 3'd5
  } cfg_mode_e;

  localparam int CTL_EN       = 0;
  localparam int CTL_NCE      = 1;
  localparam int CTL_PULL     = 2;
  localparam int CTL_RATIO_LO = 6;
  localparam int CTL_RATIO_HI = 7;
  localparam int CTL_XFER     = 8;
  localparam int CTL_WIDTH    = 9;
  localparam int CTL_BITS     = 10;
  localparam logic [CTL_BITS-1:0] CTL_WMASK = 10'h3C7;
  localparam int STAT_ERR     = 8;

  // A code is usable when its top bit is clear and its low pair is not 3.
  function automatic logic sel_code_ok(input logic [4:0] code);
    return (code[4] == 1'b0) && (code[1:0] != 2'b11);
  endfunction

  // Ratio encoding derived from the mode-select code.
  function automatic logic [1:0] sel_ratio(input logic [4:0] code);
    logic [1:0] r;
    if (code[3]) begin
      case (code[1:0])
        2'd0:    r = 2'd0;
        2'd1:    r = 2'd2;
        default: r = 2'd3;
      endcase
    end else begin
      r = code[1:0];
    end
    return r;
  endfunction

  // Keep the low n bytes (n = 0 keeps all four).
  function automatic logic [31:0] keep_bytes(input logic [31:0] d, input logic [1:0] n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (n == 2'd0 || i < int'(n)) r[8*i +: 8] = d[8*i +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_seq_regs.sv
module cfg_seq_regs
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int MSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [MSEL_W-1:0] msel_pins,
  input  cfg_mode_e         mode_i,
  input  logic              drop_i,
  output logic [MSEL_W-1:0] msel_q_o,
  output logic              en_o,
  output logic              nce_o,
  output logic              pull_o,
  output logic [1:0]        ratio_o,
  output logic              xfer_o,
  output logic              width_o
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(1);

  logic [CTL_BITS-1:0] ctl_q, ctl_nxt;
  logic [MSEL_W-1:0]   msel_q;
  logic                err_q;
  logic                ctl_wr, err_clr, load_mode;

  assign ctl_wr    = reg_wr && (reg_addr == A_CTL);
  assign err_clr   = reg_wr && (reg_addr == A_STAT) && reg_wdata[STAT_ERR];
  assign load_mode = reg_wdata[CTL_EN] && reg_wdata[CTL_PULL] && sel_code_ok(msel_q);

  always_comb begin
    ctl_nxt = reg_wdata[CTL_BITS-1:0] & CTL_WMASK;
    if (load_mode) begin
      ctl_nxt[CTL_RATIO_HI:CTL_RATIO_LO] = sel_ratio(msel_q);
      ctl_nxt[CTL_WIDTH]                 = msel_q[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      msel_q <= '0;
      err_q  <= 1'b0;
    end else begin
      msel_q <= msel_pins;
      if (ctl_wr) ctl_q <= ctl_nxt;
      if (drop_i)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT) begin
      reg_rdata[2:0]          = mode_i;
      reg_rdata[3 +: MSEL_W]  = msel_q;
      reg_rdata[STAT_ERR]     = err_q;
    end else if (reg_addr == A_CTL) begin
      reg_rdata[CTL_BITS-1:0] = ctl_q;
    end
  end

  assign msel_q_o = msel_q;
  assign en_o     = ctl_q[CTL_EN];
  assign nce_o    = ctl_q[CTL_NCE];
  assign pull_o   = ctl_q[CTL_PULL];
  assign ratio_o  = ctl_q[CTL_RATIO_HI:CTL_RATIO_LO];
  assign xfer_o   = ctl_q[CTL_XFER];
  assign width_o  = ctl_q[CTL_WIDTH];

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R8
  AST_WIDTH_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && load_mode) |=> (width_o == $past(msel_q[3]))); // R4

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int COMPL_CLKS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      pull_i,
  input  logic      code_ok_i,
  input  logic      conf_done_i,
  input  logic      nstatus_i,
  input  logic      init_done_i,
  output cfg_mode_e mode_o,
  output logic      dclk_o
);

  localparam int CNT_W = $clog2(COMPL_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(COMPL_CLKS);

  cfg_mode_e       mode_q;
  logic            armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic            cnt_run;

  assign cnt_run = (cnt_q < CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PWRUP;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en_i) begin
      if (pull_i) begin
        mode_q  <= code_ok_i ? MODE_RESET : MODE_UNKNOWN;
        armed_q <= code_ok_i;
      end else begin
        case (mode_q)
          MODE_RESET: if (armed_q) begin
            mode_q  <= MODE_CONFIG;
            armed_q <= 1'b0;
          end
          MODE_CONFIG: begin
            if (!nstatus_i) mode_q <= MODE_RESET;
            else if (conf_done_i) begin
              mode_q <= MODE_INIT;
              cnt_q  <= '0;
            end
          end
          MODE_INIT: begin
            if (cnt_run)          cnt_q  <= cnt_q + 1'b1;
            else if (init_done_i) mode_q <= MODE_USER;
          end
          default: ;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
  assign dclk_o = en_i && (mode_q == MODE_INIT) && cnt_run;

  AST_PULL_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pull_i && code_ok_i) |=> (mode_q == MODE_RESET)); // R3
  AST_BAD_CODE_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pull_i && !code_ok_i) |=> (mode_q == MODE_UNKNOWN)); // R5
  AST_NSTATUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !pull_i && mode_q == MODE_CONFIG && !nstatus_i) |=> (mode_q == MODE_RESET)); // R10
  AST_USER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_INIT && !init_done_i) |=> (mode_q != MODE_USER)); // R9
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> $stable(mode_q)); // R11

endmodule

// File: rtl/cfg_seq_datapath.sv
module cfg_seq_datapath
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr_i,
  input  logic [1:0]        nbytes_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              xfer_i,
  output logic [DATA_W-1:0] data_o,
  output logic              vld_o,
  output logic              drop_o
);

  logic              take;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  assign take   = data_wr_i && en_i && xfer_i;
  assign drop_o = data_wr_i && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) data_q <= keep_bytes(wdata_i, nbytes_i);
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && !(en_i && xfer_i)) |=> !vld_q); // R6
  AST_HIGH_BYTES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nbytes_i == 2'd1) |=> (data_q[DATA_W-1:8] == '0)); // R7

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int MSEL_W     = 5,
  parameter int COMPL_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              data_wr,
  input  logic [1:0]        data_nbytes,
  input  logic [31:0]       data_wdata,
  input  logic [MSEL_W-1:0] msel_pins,
  input  logic              fab_conf_done,
  input  logic              fab_nstatus,
  input  logic              fab_init_done,
  output logic              cfg_nconfig,
  output logic              cfg_nce,
  output logic              cfg_dclk,
  output logic              cfg_width32,
  output logic [1:0]        cfg_ratio,
  output logic [31:0]       cfg_data,
  output logic              cfg_data_vld
);

  cfg_mode_e         mode;
  logic [MSEL_W-1:0] msel_q;
  logic              en, nce_bit, pull, xfer, drop, code_ok;

  cfg_seq_regs #(.ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msel_pins(msel_pins), .mode_i(mode), .drop_i(drop), .msel_q_o(msel_q),
    .en_o(en), .nce_o(nce_bit), .pull_o(pull), .ratio_o(cfg_ratio),
    .xfer_o(xfer), .width_o(cfg_width32)
  );

  assign code_ok = sel_code_ok(msel_q);

  cfg_seq_fsm #(.COMPL_CLKS(COMPL_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pull_i(pull), .code_ok_i(code_ok),
    .conf_done_i(fab_conf_done), .nstatus_i(fab_nstatus), .init_done_i(fab_init_done),
    .mode_o(mode), .dclk_o(cfg_dclk)
  );

  cfg_seq_datapath #(.DATA_W(32)) u_data (
    .clk(clk), .rst_n(rst_n), .data_wr_i(data_wr), .nbytes_i(data_nbytes),
    .wdata_i(data_wdata), .en_i(en), .xfer_i(xfer),
    .data_o(cfg_data), .vld_o(cfg_data_vld), .drop_o(drop)
  );

  assign cfg_nconfig = !(en && pull);
  assign cfg_nce     = !en || nce_bit;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |-> (cfg_nconfig && cfg_nce && !cfg_dclk)); // R11

endmodule

// File: tb/cfg_seq_ctrl_bench.sv
module cfg_seq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        data_wr = 1'b0;
  logic [1:0]  data_nbytes = '0;
  logic [31:0] data_wdata = '0;
  logic [4:0]  msel_pins = '0;
  logic        fab_conf_done = 1'b0;
  logic        fab_nstatus = 1'b1;
  logic        fab_init_done = 1'b0;
  logic        cfg_nconfig, cfg_nce, cfg_dclk, cfg_width32, cfg_data_vld;
  logic [1:0]  cfg_ratio;
  logic [31:0] cfg_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfg_seq_ctrl u_cfg_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_wr(data_wr),
    .data_nbytes(data_nbytes), .data_wdata(data_wdata), .msel_pins(msel_pins),
    .fab_conf_done(fab_conf_done), .fab_nstatus(fab_nstatus), .fab_init_done(fab_init_done),
    .cfg_nconfig(cfg_nconfig), .cfg_nce(cfg_nce), .cfg_dclk(cfg_dclk),
    .cfg_width32(cfg_width32), .cfg_ratio(cfg_ratio), .cfg_data(cfg_data),
    .cfg_data_vld(cfg_data_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(2);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [1:0] exp_ratio(input logic [4:0] c);
    int mult;
    if (c[3]) mult = (c[1:0] == 0) ? 1 : ((c[1:0] == 1) ? 4 : 8);
    else      mult = 1 << c[1:0];
    return 2'($clog2(mult));
  endfunction

  task automatic t_reset_state();
    logic [31:0] v;
    rd_reg(2'd0, v); chk("R12 status after reset", v, 32'h0);
    rd_reg(2'd1, v); chk("R12 control after reset", v, 32'h0);
    chk("R12 outputs after reset", {cfg_nconfig, cfg_nce, cfg_dclk, cfg_data_vld}, 32'b1100);
    rd_reg(2'd3, v); chk("R1 unused address", v, 32'h0);
  endtask

  task automatic t_mode_decode();
    logic [31:0] v;
    for (int c = 0; c < 17; c++) begin
      logic [4:0] code;
      logic ok;
      code = (c == 16) ? 5'd20 : 5'(c);
      ok = (code[4] == 1'b0) && (code % 4 != 3);
      msel_pins = code;
      idle(2);
      wr_reg(2'd1, 32'h5);
      rd_reg(2'd1, v);
      if (ok) chk("R4 control loaded from code", v, {22'd0, code[3], 1'b0, exp_ratio(code), 6'h05});
      else    chk("R5 control kept on bad code", v, 32'h5);
      rd_reg(2'd0, v);
      chk("R1 status mode and pins", v[7:0], {code, ok ? 3'd1 : 3'd5});
      if (!ok) begin
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd0, v);
        chk("R5 unknown persists", v[2:0], 3'd5);
      end
      wr_reg(2'd1, 32'h0);
    end
  endtask

  task automatic t_reset_pull();
    logic [31:0] v;
    msel_pins = 5'd0; idle(2);
    wr_reg(2'd1, 32'h5);
    chk("R3 nconfig low on pull", cfg_nconfig, 1'b0);
    chk("R2 nce low when enabled", cfg_nce, 1'b0);
    rd_reg(2'd0, v); chk("R3 mode reset", v[2:0], 3'd1);
    wr_reg(2'd1, 32'h1);
    chk("R3 nconfig released", cfg_nconfig, 1'b1);
    rd_reg(2'd0, v); chk("R3 mode configuration", v[2:0], 3'd2);
  endtask

  task automatic t_ctl_fields();
    logic [31:0] v;
    wr_reg(2'd1, 32'hFFFF_FFFB);
    rd_reg(2'd1, v); chk("R2 control readback", v, 32'h3C3);
    chk("R2 field outputs", {cfg_width32, cfg_ratio, cfg_nce}, 4'b1111);
    rd_reg(2'd0, v); chk("R2 mode unaffected", v[2:0], 3'd2);
  endtask

  task automatic t_data_pass();
    wr_reg(2'd1, 32'h101);
    for (int n = 0; n < 4; n++) begin
      logic [31:0] e;
      e = (n == 0) ? 32'hA1B2C3D4 : (32'hA1B2C3D4 & ((32'h1 << (8*n)) - 1));
      @(negedge clk);
      data_wr = 1'b1; data_nbytes = 2'(n); data_wdata = 32'hA1B2C3D4;
      @(negedge clk);
      data_wr = 1'b0;
      chk("R6 word forwarded valid", cfg_data_vld, 1'b1);
      chk("R7 word masked", cfg_data, e);
      @(negedge clk);
      chk("R6 valid lasts one cycle", cfg_data_vld, 1'b0);
    end
  endtask

  task automatic t_drop_error();
    logic [31:0] v;
    wr_reg(2'd1, 32'h1);
    @(negedge clk);
    data_wr = 1'b1; data_nbytes = 2'd0; data_wdata = 32'h12345678;
    @(negedge clk);
    data_wr = 1'b0;
    chk("R6 dropped word not valid", cfg_data_vld, 1'b0);
    idle(3);
    rd_reg(2'd0, v); chk("R8 sticky error set", v[8], 1'b1);
    wr_reg(2'd0, 32'h0);
    rd_reg(2'd0, v); chk("R8 error survives zero write", v[8], 1'b1);
    wr_reg(2'd0, 32'h100);
    rd_reg(2'd0, v); chk("R8 error cleared", v[8], 1'b0);
  endtask

  task automatic t_complete();
    logic [31:0] v;
    int pulses;
    msel_pins = 5'd0; idle(2);
    wr_reg(2'd1, 32'h5);
    wr_reg(2'd1, 32'h1);
    rd_reg(2'd0, v); chk("R9 start in configuration", v[2:0], 3'd2);
    fab_init_done = 1'b0;
    @(negedge clk);
    fab_conf_done = 1'b1;
    pulses = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (cfg_dclk) pulses++;
    end
    chk("R9 completion clock count", pulses, 4);
    rd_reg(2'd0, v); chk("R9 wait in initialization", v[2:0], 3'd3);
    fab_init_done = 1'b1;
    idle(2);
    rd_reg(2'd0, v); chk("R9 user mode", v[2:0], 3'd4);
    fab_conf_done = 1'b0; fab_init_done = 1'b0;
  endtask

  task automatic t_nstatus_fail();
    logic [31:0] v;
    wr_reg(2'd1, 32'h5);
    wr_reg(2'd1, 32'h1);
    fab_nstatus = 1'b0;
    idle(2);
    rd_reg(2'd0, v); chk("R10 back to reset", v[2:0], 3'd1);
    fab_nstatus = 1'b1;
    idle(4);
    rd_reg(2'd0, v); chk("R10 stays in reset", v[2:0], 3'd1);
    wr_reg(2'd1, 32'h5);
    wr_reg(2'd1, 32'h1);
    rd_reg(2'd0, v); chk("R10 new pull cycle", v[2:0], 3'd2);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr_reg(2'd1, 32'h100);
    fab_nstatus = 1'b0;
    idle(3);
    rd_reg(2'd0, v); chk("R11 mode frozen", v[2:0], 3'd2);
    wr_reg(2'd1, 32'h104);
    chk("R11 outputs inactive", {cfg_nconfig, cfg_nce, cfg_dclk}, 3'b110);
    rd_reg(2'd0, v); chk("R11 pull ignored", v[2:0], 3'd2);
    @(negedge clk);
    data_wr = 1'b1; data_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    data_wr = 1'b0;
    chk("R11 no data while disabled", cfg_data_vld, 1'b0);
    fab_nstatus = 1'b1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset_state();
    t_mode_decode();
    t_reset_pull();
    t_ctl_fields();
    t_data_pass();
    t_drop_error();
    t_complete();
    t_nstatus_fail();
    t_disabled();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule